// File: doc/BRIEF.md
# Bitmask Peripheral Reset Controller

This block holds the reset lines of up to 32 peripherals in one register domain. Software writes a request word in which each bit controls one peripheral reset. The encoding is active-low: a 0 bit holds that peripheral in reset and a 1 bit lets it run. The request bits drive the reset outputs directly, so a change reaches the peripheral on the clock edge that takes the write.

A second word, the settle status, shows when each reset has actually taken effect. Each implemented bit has its own down-counter that models the peripheral's acknowledge delay. The status bit copies the request bit a fixed number of clock cycles after the last change of that request bit. Software polls the status word and treats a status that does not arrive in time as a timeout.

A build-time mask picks which bit positions exist. Positions outside the mask never store a value, never toggle, and always read as 0.

Top module: `bitrst_ctrl`

## Requirements
- R1: After reset the request word, the settle status word and every `periph_rst_n` output are 0, so all peripherals start held in reset.
- R2: A bus write with `bus_addr` = 0x0 stores `bus_wdata & VALID_MASK` as the request word. A read at 0x0 returns that word in the same cycle.
- R3: `periph_rst_n[i]` equals request bit i, where 0 means held in reset. It changes on the clock edge that takes a request write and at no other time.
- R4: When request bit i changes on write edge E, settle status bit i keeps its old value through edge E+SETTLE_CYCLES-1 and takes the new request value on edge E+SETTLE_CYCLES. A status bit changes only on such a settle edge.
- R5: A further change of request bit i before its settle edge restarts that bit's count from the newest change. The status does not change on the edge of the restarting write, and a change that is reverted before settling never appears on the status.
- R6: A write that leaves request bit i unchanged does not restart bit i's count.
- R7: Bits outside VALID_MASK read as 0 at both offsets, and their `periph_rst_n` and status bits stay 0 for any write data. With the default mask 0x0FFFFFF8, these are bits 0-2 and 28-31.
- R8: Writes to any offset other than 0x0 (including the status offset 0x4) leave the request word and `periph_rst_n` unchanged.
- R9: A read at 0x4 returns the settle status word. A read at any other offset besides 0x0 and 0x4 returns 0, and `bus_rdata` is 0 when `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the domain window |
| bus_wdata | input | NUM_BITS | Write data |
| bus_rdata | output | NUM_BITS | Read data, combinational from address |
| periph_rst_n | output | NUM_BITS | Per-peripheral active-low reset |

## Verification
Read data is combinational, so the bench drives the address on a falling edge and samples after a short delay, with no clock edge in between. A request write takes effect on the next rising edge, and `periph_rst_n` is checked at the falling edge that follows. The status of a changed bit is checked twice, counting falling edges from the write edge: after SETTLE_CYCLES-1 rising edges it must still show the old value, and after SETTLE_CYCLES edges it must show the new one. The restart and no-restart cases use the same counting, measured from the last write that toggled the bit.

// File: rtl/bitrst_pkg.sv
package bitrst_pkg;

  // Byte offsets of the two words in the domain window
  localparam int unsigned REQ_WORD_OFF  = 0;
  localparam int unsigned STAT_WORD_OFF = 4;

  // Width of a counter that holds values 0..settle
  function automatic int unsigned settle_cnt_w(input int unsigned settle);
    return (settle < 1) ? 1 : $clog2(settle + 1);
  endfunction

  // Request word after a write: positions outside the mask never store data
  function automatic logic [31:0] masked_word(input logic [31:0] mask,
                                              input logic [31:0] data);
    return data & mask;
  endfunction

  // True when bit idx of the mask is an implemented position
  function automatic bit lane_present(input logic [31:0] mask, input int idx);
    return mask[idx];
  endfunction

endpackage

// File: rtl/bitrst_regif.sv
module bitrst_regif
  import bitrst_pkg::*;
#(
  parameter int unsigned NUM_BITS   = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter logic [31:0] VALID_MASK = 32'h0FFF_FFF8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_BITS-1:0] bus_wdata,
  input  logic [NUM_BITS-1:0] stat_word,
  output logic [NUM_BITS-1:0] req_word,
  output logic [NUM_BITS-1:0] req_toggle,
  output logic [NUM_BITS-1:0] bus_rdata
);

  localparam logic [NUM_BITS-1:0] LANE_MASK = VALID_MASK[NUM_BITS-1:0];
  localparam logic [ADDR_W-1:0]   REQ_ADR   = ADDR_W'(REQ_WORD_OFF);
  localparam logic [ADDR_W-1:0]   STAT_ADR  = ADDR_W'(STAT_WORD_OFF);

  logic                req_wr_hit;
  logic [NUM_BITS-1:0] req_next;

  assign req_wr_hit = bus_sel && bus_wr && (bus_addr == REQ_ADR);
  assign req_next   = req_wr_hit ? (bus_wdata & LANE_MASK) : req_word;
  assign req_toggle = req_next ^ req_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_word <= '0;
    else        req_word <= req_next;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == REQ_ADR)       bus_rdata = req_word;
      else if (bus_addr == STAT_ADR) bus_rdata = stat_word & LANE_MASK;
    end
  end

endmodule

// File: rtl/bitrst_lane.sv
module bitrst_lane
  import bitrst_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit,
  input  logic toggle,
  output logic stat_bit,
  output logic settle_done
);

  localparam int unsigned CW = settle_cnt_w(SETTLE_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt;

  // A toggle on the final edge wins: the count reloads and the status holds
  assign settle_done = (cnt == LAST) && !toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      stat_bit <= 1'b0;
    end else begin
      if (toggle)          cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - LAST;
      if (settle_done)     stat_bit <= req_bit;
    end
  end

endmodule

// File: rtl/bitrst_ctrl.sv
module bitrst_ctrl
  import bitrst_pkg::*;
#(
  parameter int unsigned NUM_BITS      = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter logic [31:0] VALID_MASK    = 32'h0FFF_FFF8,
  parameter int unsigned SETTLE_CYCLES = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_BITS-1:0] bus_wdata,
  output logic [NUM_BITS-1:0] bus_rdata,
  output logic [NUM_BITS-1:0] periph_rst_n
);

  logic [NUM_BITS-1:0] req_word;
  logic [NUM_BITS-1:0] lane_toggle;
  logic [NUM_BITS-1:0] lane_done;
  logic [NUM_BITS-1:0] stat_word;

  bitrst_regif #(
    .NUM_BITS  (NUM_BITS),
    .ADDR_W    (ADDR_W),
    .VALID_MASK(VALID_MASK)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_word (stat_word),
    .req_word  (req_word),
    .req_toggle(lane_toggle),
    .bus_rdata (bus_rdata)
  );

  for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_lane
    if (lane_present(VALID_MASK, gi)) begin : g_on
      bitrst_lane #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
      ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_bit    (req_word[gi]),
        .toggle     (lane_toggle[gi]),
        .stat_bit   (stat_word[gi]),
        .settle_done(lane_done[gi])
      );
    end else begin : g_off
      assign stat_word[gi] = 1'b0;
      assign lane_done[gi] = 1'b0;
    end
  end

  assign periph_rst_n = req_word;

endmodule

// File: rtl/bitrst_ctrl_chk.sv
module bitrst_ctrl_chk #(
  parameter int unsigned NUM_BITS   = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter logic [31:0] VALID_MASK = 32'h0FFF_FFF8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_BITS-1:0] periph_rst_n,
  input logic [NUM_BITS-1:0] stat_word,
  input logic [NUM_BITS-1:0] lane_toggle,
  input logic [NUM_BITS-1:0] lane_done
);

  localparam logic [NUM_BITS-1:0] OFF_MASK = ~VALID_MASK[NUM_BITS-1:0];

  logic req_write;
  assign req_write = bus_sel && bus_wr && (bus_addr == '0);

  AST_RST_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(periph_rst_n) |-> $past(req_write)); // R3

  AST_OTHER_OFF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != '0) |=> $stable(periph_rst_n)); // R8

  AST_STAT_ONLY_ON_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_word) |-> $past(|lane_done)); // R4

  AST_SETTLE_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_done) |=> ((stat_word ^ periph_rst_n) & $past(lane_done)) == '0); // R4

  AST_TOGGLE_HOLDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_toggle) |=> ((stat_word ^ $past(stat_word)) & $past(lane_toggle)) == '0); // R5

  AST_HOLES_STAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_rst_n | stat_word) & OFF_MASK) == '0); // R7

endmodule

bind bitrst_ctrl bitrst_ctrl_chk #(
  .NUM_BITS  (NUM_BITS),
  .ADDR_W    (ADDR_W),
  .VALID_MASK(VALID_MASK)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .periph_rst_n(periph_rst_n),
  .stat_word   (stat_word),
  .lane_toggle (lane_toggle),
  .lane_done   (lane_done)
);

// File: tb/test_bitrst_ctrl.sv
module test_bitrst_ctrl;

  localparam int          CLK_PERIOD = 10;
  localparam int          NB         = 32;
  localparam int          AW         = 4;
  localparam logic [31:0] MASK       = 32'h0FFF_FFF8;
  localparam int          D          = 12;

  // {write data, expected stored request}
  localparam logic [63:0] VEC [7] = '{
    {32'hFFFF_FFFF, 32'h0FFF_FFF8},
    {32'h0000_0000, 32'h0000_0000},
    {32'hA5A5_A5A5, 32'h05A5_A5A0},
    {32'h1234_5678, 32'h0234_5678},
    {32'h0000_0007, 32'h0000_0000},
    {32'hF000_0000, 32'h0000_0000},
    {32'h0FFF_FFF8, 32'h0FFF_FFF8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NB-1:0] bus_wdata = '0;
  logic [NB-1:0] bus_rdata;
  logic [NB-1:0] periph_rst_n;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrst_ctrl #(
    .NUM_BITS(NB), .ADDR_W(AW), .VALID_MASK(MASK), .SETTLE_CYCLES(D)
  ) i_bitrst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_rst_n(periph_rst_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rv;
  logic [31:0] prev;

  initial begin
    step(3);
    // R1: reset state
    check("R1 periph_rst_n in reset", periph_rst_n, 32'h0);
    rst_n = 1'b1;
    step(1);
    rd(4'h0, rv); check("R1 request after reset", rv, 32'h0);
    rd(4'h4, rv); check("R1 status after reset", rv, 32'h0);
    check("R1 periph_rst_n after reset", periph_rst_n, 32'h0);

    // Vector walk: R2 R3 R4 R7 R9
    prev = 32'h0;
    foreach (VEC[vi]) begin
      wr(4'h0, VEC[vi][63:32]);
      rd(4'h0, rv); check("R2 request readback", rv, VEC[vi][31:0]);
      check("R3 periph_rst_n follows request", periph_rst_n, VEC[vi][31:0]);
      check("R7 holes zero", periph_rst_n & ~MASK, 32'h0);
      step(D - 1);
      rd(4'h4, rv); check("R4 status before settle", rv, prev);
      step(1);
      rd(4'h4, rv); check("R4/R9 status at settle", rv, VEC[vi][31:0]);
      prev = VEC[vi][31:0];
    end

    // R8: writes elsewhere do nothing
    wr(4'h4, 32'h0000_0000);
    rd(4'h0, rv); check("R8 status-offset write ignored", rv, 32'h0FFF_FFF8);
    wr(4'h8, 32'h0000_0000);
    check("R8 other-offset write ignored", periph_rst_n, 32'h0FFF_FFF8);
    step(D + 1);
    rd(4'h4, rv); check("R8 status unchanged", rv, 32'h0FFF_FFF8);
    // R9: unmapped reads and idle bus
    rd(4'h8, rv); check("R9 unmapped read zero", rv, 32'h0);
    rd(4'hC, rv); check("R9 unmapped read zero", rv, 32'h0);
    #1 check("R9 idle rdata zero", bus_rdata, 32'h0);

    // Settle to 0x8
    wr(4'h0, 32'h0000_0008);
    step(D + 1);
    rd(4'h4, rv); check("R4 status settled 0x8", rv, 32'h8);

    // R5 restart: toggles at E0, E4, E8
    wr(4'h0, 32'h0);
    step(3);
    wr(4'h0, 32'h8);
    step(3);
    wr(4'h0, 32'h0);
    step(D - 1);
    rd(4'h4, rv); check("R5 restart holds old status", rv, 32'h8);
    step(1);
    rd(4'h4, rv); check("R5 settle from last toggle", rv, 32'h0);

    // R5 reverted change never shows
    wr(4'h0, 32'h8);
    step(4);
    wr(4'h0, 32'h0);
    for (int k = 0; k < D + 2; k++) begin
      rd(4'h4, rv); check("R5 reverted change hidden", rv, 32'h0);
      step(1);
    end

    // R6 same-value rewrite does not restart
    wr(4'h0, 32'h8);
    step(3);
    wr(4'h0, 32'h8);
    step(D - 5);
    rd(4'h4, rv); check("R6 status before settle", rv, 32'h0);
    step(1);
    rd(4'h4, rv); check("R6 settle not delayed by rewrite", rv, 32'h8);

    // R7 holes with all-ones
    wr(4'h0, 32'hFFFF_FFFF);
    step(D + 1);
    rd(4'h4, rv); check("R7 status holes zero", rv & ~MASK, 32'h0);
    check("R7 periph holes zero", periph_rst_n & ~MASK, 32'h0);

    // R1 again: mid-run reset
    rst_n = 1'b0;
    step(1);
    check("R1 periph_rst_n on reset", periph_rst_n, 32'h0);
    rst_n = 1'b1;
    step(1);
    rd(4'h4, rv); check("R1 status on reset", rv, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule